// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Kick Handshake

This block derives a clock-enable stream from the parent clock. Every parent cycle it can either pass or swallow an enable pulse. The average rate is the parent rate times a multiplier over 32, then divided by a fixed post-divider. The multiplier is 32 minus a 5-bit field, so a field of 0 gives full rate and a field of 31 gives one pulse in 32. Across each 32-cycle window, a phase accumulator spreads the surviving pulses as evenly as it can.

Software sets the ratio through a small register port. It first writes the field into the control word, which stages it. It then sets the kick bit in a separate kick register. The block holds the staged value until the current 32-cycle window ends, and loads it into the active ratio only at that boundary. The kick bit clears itself a fixed number of cycles later. The kick bit reads as a busy flag. While it is set, the block ignores further field writes and further kicks.

Top module: `frac_clken_div`

## Requirements
- R1: On synchronous active-high reset, the staged and active fields are both 0 (full rate), the kick bit reads 0, and `clk_en` is low.
- R2: The active multiplier is m = 32 - field. In any run of 96 parent cycles with a constant m, exactly m*3 raw pulses occur, so exactly m*3/POST_DIV enables are produced when POST_DIV is 3.
- R3: Within a window of phases k = 0..31, a raw pulse occurs at phase k exactly when floor((k+1)*m/32) > floor(k*m/32).
- R4: `clk_en` is high for one cycle, one cycle after every POST_DIV-th raw pulse. The raw-pulse count carries across windows.
- R5: The control word (`wr_sel`/`rd_sel` = 0) holds the field in bits FIELD_LSB+4..FIELD_LSB. A read returns the staged field there and zeros in every other bit.
- R6: The kick register (select = 1) holds the kick bit at bit 31. Writing a 1 there sets it, and a read returns it at bit 31 with all other bits zero. Writing a 0 has no effect.
- R7: A staged field does not change the output until a kick has been issued and the next window boundary (phase 31 to phase 0) has been reached. The new ratio governs the output from phase 0 of the following window.
- R8: The kick bit clears exactly KICK_LAT cycles after the boundary edge at which the new ratio was loaded.
- R9: A control-word write made while the kick bit is set is ignored. The readback and the output remain those of the earlier setting.
- R10: A field of 31 (m = 1) yields exactly one raw pulse per window, at phase 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 kick register |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 control word, 1 kick register |
| rd_data | output | 32 | Combinational read data |
| clk_en | output | 1 | Clock-enable pulse output |

## Verification
The bench builds the block with FIELD_LSB = 12, POST_DIV = 3 and KICK_LAT = 3, not with the defaults. Placing the field off bit 0 exposes any decode that ignores the offset. A post-divider of 3 makes the enable count carry across window boundaries instead of lining up with them. A settle delay of 3 separates the boundary edge from the edge at which the kick bit clears. Under these settings the bench exercises full rate, an odd multiplier, half rate and the minimum multiplier. It also covers a write that lands while busy, a field write with stray bits set, and a kick-register write of zero.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int MF_W     = 5;
    localparam int WIN_LEN  = 32;
    localparam int PH_W     = 5;
    localparam int MUL_W    = 6;
    localparam int WORD_W   = 32;
    localparam int KICK_BIT = 31;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_KICK = 1'b1;

    typedef enum logic [1:0] {
        KS_IDLE   = 2'd0,
        KS_WAIT   = 2'd1,
        KS_SETTLE = 2'd2
    } kick_st_e;

    typedef struct packed {
        logic              we;
        logic              sel;
        logic [WORD_W-1:0] data;
    } reg_wr_t;

    function automatic logic [MUL_W-1:0] mult_of(input logic [MF_W-1:0] field);
        return MUL_W'(WIN_LEN) - MUL_W'(field);
    endfunction

endpackage

// File: rtl/fcd_regs.sv
module fcd_regs
    import fcd_pkg::*;
#(
    parameter int FIELD_LSB = 8,
    parameter int KICK_LAT  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr,
    input  logic              rd_sel,
    input  logic              window_end,
    output logic [WORD_W-1:0] rd_data,
    output logic [MF_W-1:0]   act_field,
    output logic [MF_W-1:0]   staged_field,
    output logic              busy
);
    localparam int CNT_W = (KICK_LAT > 1) ? $clog2(KICK_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(KICK_LAT - 1);

    kick_st_e         st;
    logic [CNT_W-1:0] cnt;
    logic             ctrl_wr_ok;
    logic             kick_req;

    assign busy       = (st != KS_IDLE);
    assign ctrl_wr_ok = wr.we && (wr.sel == SEL_CTRL) && !busy;
    assign kick_req   = wr.we && (wr.sel == SEL_KICK) && wr.data[KICK_BIT] && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= KS_IDLE;
            cnt          <= '0;
            act_field    <= '0;
            staged_field <= '0;
        end else begin
            case (st)
                KS_IDLE: begin
                    if (ctrl_wr_ok)
                        staged_field <= wr.data[FIELD_LSB +: MF_W];
                    if (kick_req)
                        st <= KS_WAIT;
                end
                KS_WAIT: begin
                    if (window_end) begin
                        act_field <= staged_field;
                        cnt       <= '0;
                        st        <= KS_SETTLE;
                    end
                end
                KS_SETTLE: begin
                    if (cnt == CNT_LAST)
                        st <= KS_IDLE;
                    else
                        cnt <= cnt + 1'b1;
                end
                default: st <= KS_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_CTRL)
            rd_data[FIELD_LSB +: MF_W] = staged_field;
        else
            rd_data[KICK_BIT] = busy;
    end

endmodule

// File: rtl/fcd_swallow.sv
module fcd_swallow
    import fcd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [MF_W-1:0] act_field,
    output logic            raw_pulse,
    output logic            window_end,
    output logic [PH_W-1:0] phase,
    output logic [PH_W-1:0] acc
);
    logic [MUL_W-1:0] mult;
    logic [MUL_W-1:0] sum;

    assign mult       = mult_of(act_field);
    assign sum        = {1'b0, acc} + mult;
    assign raw_pulse  = sum[MUL_W-1];
    assign window_end = (phase == PH_W'(WIN_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            acc   <= '0;
        end else begin
            phase <= phase + 1'b1;
            acc   <= sum[PH_W-1:0];
        end
    end

endmodule

// File: rtl/fcd_postdiv.sv
module fcd_postdiv #(
    parameter int POST_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_pulse,
    output logic clk_en
);
    generate
        if (POST_DIV <= 1) begin : g_pass
            always_ff @(posedge clk) begin
                if (rst) clk_en <= 1'b0;
                else     clk_en <= raw_pulse;
            end
        end else begin : g_count
            localparam int PC_W = $clog2(POST_DIV);
            localparam logic [PC_W-1:0] PC_LAST = PC_W'(POST_DIV - 1);
            logic [PC_W-1:0] pcnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pcnt   <= '0;
                    clk_en <= 1'b0;
                end else begin
                    clk_en <= raw_pulse && (pcnt == PC_LAST);
                    if (raw_pulse)
                        pcnt <= (pcnt == PC_LAST) ? '0 : pcnt + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/frac_clken_div.sv
module frac_clken_div
    import fcd_pkg::*;
#(
    parameter int FIELD_LSB = 8,
    parameter int POST_DIV  = 2,
    parameter int KICK_LAT  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    input  logic        rd_sel,
    output logic [31:0] rd_data,
    output logic        clk_en
);
    reg_wr_t         wr;
    logic [MF_W-1:0] act_field;
    logic [MF_W-1:0] staged_field;
    logic            busy;
    logic            raw_pulse;
    logic            window_end;
    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] acc;

    assign wr = '{we: wr_en, sel: wr_sel, data: wr_data};

    fcd_regs #(
        .FIELD_LSB (FIELD_LSB),
        .KICK_LAT  (KICK_LAT)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr           (wr),
        .rd_sel       (rd_sel),
        .window_end   (window_end),
        .rd_data      (rd_data),
        .act_field    (act_field),
        .staged_field (staged_field),
        .busy         (busy)
    );

    fcd_swallow u_swallow (
        .clk        (clk),
        .rst        (rst),
        .act_field  (act_field),
        .raw_pulse  (raw_pulse),
        .window_end (window_end),
        .phase      (phase),
        .acc        (acc)
    );

    fcd_postdiv #(
        .POST_DIV (POST_DIV)
    ) u_postdiv (
        .clk       (clk),
        .rst       (rst),
        .raw_pulse (raw_pulse),
        .clk_en    (clk_en)
    );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       wr_sel,
    input logic       clk_en,
    input logic [4:0] act_field,
    input logic [4:0] staged_field,
    input logic       busy,
    input logic       raw_pulse,
    input logic [4:0] phase,
    input logic [4:0] acc
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: state right after a reset cycle
    always @(posedge clk) begin
        if (rst_q && !rst)
            a_r1_reset_state: assert (!busy && act_field == 5'd0 && staged_field == 5'd0 && !clk_en);
    end

    // R7: active ratio moves only across a window boundary
    a_r7_load_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_field) |-> $past(phase) == 5'd31);

    // R9: control writes while busy leave the staged field alone
    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && !wr_sel) |=> $stable(staged_field));

    // R2: full-rate field passes every parent cycle
    a_r2_full_rate: assert property (@(posedge clk) disable iff (rst)
        (act_field == 5'd0) |-> raw_pulse);

    // R4: an enable always follows a raw pulse
    a_r4_en_after_raw: assert property (@(posedge clk) disable iff (rst)
        clk_en |-> $past(raw_pulse));

    // R3: accumulator returns to zero at each window start
    a_r3_window_start_zero: assert property (@(posedge clk) disable iff (rst)
        (phase == 5'd0) |-> (acc == 5'd0));

endmodule

bind frac_clken_div fcd_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .clk_en       (clk_en),
    .act_field    (act_field),
    .staged_field (staged_field),
    .busy         (busy),
    .raw_pulse    (raw_pulse),
    .phase        (phase),
    .acc          (acc)
);

// File: tb/frac_clken_div_tb.sv
module frac_clken_div_tb;
    localparam int FL = 12;
    localparam int PD = 3;
    localparam int KL = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        clk_en;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    frac_clken_div #(.FIELD_LSB(FL), .POST_DIV(PD), .KICK_LAT(KL)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .clk_en(clk_en)
    );

    // behavioural reference
    int m_ph = 0, m_act = 0, m_stg = 0, m_ks = 0, m_kc = 0, m_pc = 0;
    bit m_en = 0;

    function automatic bit pulse_at(int k, int m);
        return ((k + 1) * m) / 32 != (k * m) / 32;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_ph = 0; m_act = 0; m_stg = 0; m_ks = 0; m_kc = 0; m_pc = 0; m_en = 0;
        end else begin
            bit raw;
            raw = pulse_at(m_ph, 32 - m_act);
            m_en = raw && (m_pc == PD - 1);
            if (raw) m_pc = (m_pc == PD - 1) ? 0 : m_pc + 1;
            if (m_ks == 0) begin
                if (wr_en && !wr_sel) m_stg = int'(wr_data[FL +: 5]);
                if (wr_en && wr_sel && wr_data[31]) m_ks = 1;
            end else if (m_ks == 1) begin
                if (m_ph == 31) begin m_act = m_stg; m_ks = 2; m_kc = 0; end
            end else begin
                if (m_kc == KL - 1) m_ks = 0; else m_kc++;
            end
            m_ph = (m_ph + 1) % 32;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            check(clk_en == m_en, "R3 clk_en vs model", clk_en, m_en);
            if (rd_sel) begin
                logic [31:0] ek;
                ek = (m_ks != 0) ? 32'h8000_0000 : 32'h0;
                check(rd_data == ek, "R8 kick readback vs model", rd_data, ek);
            end else begin
                logic [31:0] ec;
                ec = 32'(m_stg) << FL;
                check(rd_data == ec, "R5 ctrl readback vs model", rd_data, ec);
            end
        end
    end

    task automatic wr(input bit sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input bit sel, output logic [31:0] d);
        @(negedge clk);
        rd_sel = sel;
        #1 d = rd_data;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 200; i++) begin
            rd(1'b1, d);
            if (!d[31]) break;
        end
        check(d[31] == 1'b0, "R8 kick cleared", d, 0);
    endtask

    task automatic count_en(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1 if (clk_en) c++;
        end
    endtask

    task automatic set_ratio(input int field);
        wr(1'b0, 32'(field) << FL);
        wr(1'b1, 32'h8000_0000);
        wait_idle();
        repeat (40) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        int c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(1'b0, d); check(d == 0, "R1 ctrl after reset", d, 0);
        rd(1'b1, d); check(d == 0, "R1 kick after reset", d, 0);
        check(clk_en == 1'b0, "R1 clk_en after reset", clk_en, 0);
        // R2 full rate: m=32 -> 32 enables in 96 cycles
        repeat (10) @(negedge clk);
        count_en(96, c); check(c == 32, "R2 full-rate count", c, 32);
        // R5 field placement with stray bits
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, d); check(d == (32'h1F << FL), "R5 stray bits masked", d, 32'h1F << FL);
        wr(1'b0, 32'd5 << FL);
        rd(1'b0, d); check(d == (32'd5 << FL), "R5 field readback", d, 32'd5 << FL);
        // R7 staged only: still full rate
        count_en(96, c); check(c == 32, "R7 staged field not yet active", c, 32);
        // R6 write of zero to kick does nothing
        wr(1'b1, 32'h0);
        rd(1'b1, d); check(d == 0, "R6 zero kick ignored", d, 0);
        count_en(96, c); check(c == 32, "R6 rate unchanged after zero kick", c, 32);
        // R6 kick sets, R9 write while busy ignored
        wr(1'b1, 32'h8000_0000);
        rd(1'b1, d); check(d == 32'h8000_0000, "R6 kick set", d, 32'h8000_0000);
        wr(1'b0, 32'd20 << FL);
        rd(1'b0, d); check(d == (32'd5 << FL), "R9 busy write ignored", d, 32'd5 << FL);
        wait_idle();
        rd(1'b0, d); check(d == (32'd5 << FL), "R9 readback after settle", d, 32'd5 << FL);
        repeat (40) @(negedge clk);
        count_en(96, c); check(c == 27, "R2 m=27 count", c, 27);
        // R3 half rate
        set_ratio(16);
        count_en(96, c); check(c == 16, "R3 m=16 count", c, 16);
        // R10 minimum multiplier
        set_ratio(31);
        count_en(96, c); check(c == 1, "R10 m=1 count", c, 1);
        // R4 post-divider across windows with odd m
        set_ratio(25);
        count_en(288, c); check(c == 7 * 3, "R4 m=7 over 9 windows", c, 21);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule